// File: doc/BRIEF.md
# Heartbeat and Run-Overrun Supervisor

This block drives a single heartbeat line towards an external supervisor, which resets or reconfigures the device when the line stops changing. While the processing logic is healthy, the line keeps moving at a rate set by a unit prescaler. Each repetition is a frame of pulse widths. A long high pulse opens the frame. A low gap follows. Then come three code bits, most significant first, each sent as a short or a long high pulse and each followed by a low gap. In this way the supervisor can read a small state code from the shape of the line, as well as whether the line is moving.

Two faults hold the line flat (low). The first is a missing "alive" strobe from the main control logic. This condition clears itself when the strobe returns, and the next frame then begins from its start pulse. The second is a processing run that lasts longer than its allowed duration, measured from the run-start strobe to the run-done strobe. An overrun is latched and holds the line flat until the synchronous reset, so to the supervisor it looks exactly like a hung device. The latch that records the overrun can be kept as three voted copies. This is chosen by a parameter, because the block guards a severely critical function.

Top module: `hb_supervisor`

## Requirements
- R1: After a reset edge, hb_out is high in the cycle that follows. The opening start pulse stays high for START_U*UNIT_CYC cycles, counted from that reset edge (default 4*4 = 16).
- R2: A frame is, in order: a high start pulse of START_U units; a low gap of GAP_U units; then code bit 2, bit 1 and bit 0. Each bit is a high pulse followed by a low gap of GAP_U units. After the last gap the frame repeats from the start pulse. One unit is UNIT_CYC clock cycles.
- R3: state_code is sampled only at the clock edge that ends the start pulse. A change at any other time has no effect on the frame in progress.
- R4: A code bit of value 0 is a high pulse of SHORT_U units (default 1). A code bit of value 1 is a high pulse of LONG_U units (default 2).
- R5: Once ALIVE_LIMIT consecutive edges have sampled alive low, hb_out is low from the cycle after the last of those edges. It stays low while alive stays low.
- R6: The edge that samples alive high ends the starved condition. hb_out is high from the next cycle, and a full frame begins with its start pulse.
- R7: A run begins at the edge that samples run_start. If run_done is sampled no later than RUN_LIMIT+1 edges after that edge, no fault is recorded.
- R8: If RUN_LIMIT+1 edges pass after run_start without run_done, an overrun fault is latched. hb_out is then low from the next cycle until reset, whatever alive, run_start or run_done do.
- R9: When run_start and run_done are sampled at the same edge, a new run begins with its count at zero. A run_done sampled while no run is active has no effect.
- R10: A synchronous reset (rst_n low at a clock edge) clears a latched overrun. hb_out is high in the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| alive | input | 1 | Health strobe from the control logic |
| run_start | input | 1 | Strobe that opens a processing run |
| run_done | input | 1 | Strobe that closes the current run |
| state_code | input | 3 | Code sent in the heartbeat frame |
| hb_out | output | 1 | Heartbeat line to the external supervisor |

## Verification
Two pairs of events can fall in the same cycle. The first pair is run_done and the last permitted edge of a run. The bench places run_done on exactly the RUN_LIMIT+1st edge after run_start and expects no fault. The second pair is run_start and run_done together during an active run. The bench issues both at one edge and then lets the restarted run last long enough that it would have overrun if the count had not been zeroed. The behavioural reference model decides every cycle whether a fault is latched and what hb_out shows, and the outcome is judged from there.

// File: rtl/hb_pkg.sv
package hb_pkg;

  // Majority of three copies of a critical flag.
  function automatic logic maj3(input logic [2:0] v);
    return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
  endfunction

  // Segment index inside a frame; even segments drive the line high.
  typedef logic [2:0] seg_t;

  localparam seg_t SEG_START = 3'd0;
  localparam seg_t SEG_LAST  = 3'd7;

endpackage

// File: rtl/hb_tick.sv
module hb_tick #(
  parameter int unsigned UNIT_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int unsigned CW = (UNIT_CYC > 1) ? $clog2(UNIT_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(UNIT_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick = (cnt_q == LAST) && !clr;

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R2

endmodule

// File: rtl/hb_watch.sv
module hb_watch #(
  parameter int unsigned ALIVE_LIMIT = 100,
  parameter int unsigned RUN_LIMIT   = 300,
  parameter bit          TRIPLE      = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic alive,
  input  logic run_start,
  input  logic run_done,
  output logic starved,
  output logic fault
);
  import hb_pkg::*;

  localparam int unsigned AW = $clog2(ALIVE_LIMIT + 1);
  localparam int unsigned RW = $clog2(RUN_LIMIT + 1);
  localparam logic [AW-1:0] A_MAX = AW'(ALIVE_LIMIT);
  localparam logic [RW-1:0] R_MAX = RW'(RUN_LIMIT);

  logic [AW-1:0] alive_cnt_q;
  logic [RW-1:0] run_cnt_q;
  logic          busy_q;
  logic          overrun_set;

  // Alive-strobe starvation counter (saturating).
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alive_cnt_q <= '0;
    end else if (alive) begin
      alive_cnt_q <= '0;
    end else if (alive_cnt_q != A_MAX) begin
      alive_cnt_q <= alive_cnt_q + 1'b1;
    end
  end

  assign starved = (alive_cnt_q == A_MAX);

  // Run duration timer: start wins over done, done while idle is harmless.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      run_cnt_q <= '0;
    end else if (run_start) begin
      busy_q    <= 1'b1;
      run_cnt_q <= '0;
    end else if (run_done) begin
      busy_q    <= 1'b0;
      run_cnt_q <= '0;
    end else if (busy_q && (run_cnt_q != R_MAX)) begin
      run_cnt_q <= run_cnt_q + 1'b1;
    end
  end

  assign overrun_set = busy_q && (run_cnt_q == R_MAX) && !run_done && !run_start;

  // Overrun latch, optionally held as three voted copies.
  generate
    if (TRIPLE) begin : g_tmr
      logic [2:0] copy_q;
      logic       voted;
      assign voted = maj3(copy_q);
      for (genvar i = 0; i < 3; i++) begin : g_copy
        always_ff @(posedge clk) begin
          if (!rst_n) begin
            copy_q[i] <= 1'b0;
          end else begin
            copy_q[i] <= voted | overrun_set;
          end
        end
      end
      assign fault = voted;
    end else begin : g_single
      logic one_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          one_q <= 1'b0;
        end else begin
          one_q <= one_q | overrun_set;
        end
      end
      assign fault = one_q;
    end
  endgenerate

  AST_OVERRUN_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && run_cnt_q == R_MAX && !run_done && !run_start) |=> fault); // R8

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault); // R8

  AST_ALIVE_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    alive |=> !starved); // R6

  AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    run_start |=> (busy_q && run_cnt_q == '0)); // R9

endmodule

// File: rtl/hb_frame.sv
module hb_frame #(
  parameter int unsigned START_U = 4,
  parameter int unsigned SHORT_U = 1,
  parameter int unsigned LONG_U  = 2,
  parameter int unsigned GAP_U   = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       tick,
  input  logic [2:0] code,
  output logic       level
);
  import hb_pkg::*;

  localparam int unsigned MAX_A = (START_U > LONG_U) ? START_U : LONG_U;
  localparam int unsigned MAX_U = (MAX_A > GAP_U) ? MAX_A : GAP_U;
  localparam int unsigned UW    = $clog2(MAX_U + 1);

  seg_t          seg_q;
  logic [UW-1:0] left_q;
  logic [2:0]    code_q;
  seg_t          seg_nx;

  function automatic logic [UW-1:0] seg_len(input seg_t s, input logic [2:0] c);
    logic bitv;
    if (s[0]) return UW'(GAP_U);
    case (s[2:1])
      2'd0:    return UW'(START_U);
      2'd1:    bitv = c[2];
      2'd2:    bitv = c[1];
      default: bitv = c[0];
    endcase
    return bitv ? UW'(LONG_U) : UW'(SHORT_U);
  endfunction

  assign seg_nx = (seg_q == SEG_LAST) ? SEG_START : seg_q + 3'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg_q  <= SEG_START;
      left_q <= UW'(START_U);
      code_q <= '0;
    end else if (restart) begin
      seg_q  <= SEG_START;
      left_q <= UW'(START_U);
    end else if (tick) begin
      if (left_q == UW'(1)) begin
        seg_q  <= seg_nx;
        left_q <= seg_len(seg_nx, code_q);
        if (seg_q == SEG_START) begin
          code_q <= code;
        end
      end else begin
        left_q <= left_q - 1'b1;
      end
    end
  end

  assign level = ~seg_q[0];

  AST_SEG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart) |=> $stable(seg_q)); // R2

  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_q != SEG_START) |=> $stable(code_q)); // R3

endmodule

// File: rtl/hb_supervisor.sv
module hb_supervisor #(
  parameter int unsigned UNIT_CYC    = 4,
  parameter int unsigned START_U     = 4,
  parameter int unsigned SHORT_U     = 1,
  parameter int unsigned LONG_U      = 2,
  parameter int unsigned GAP_U       = 1,
  parameter int unsigned ALIVE_LIMIT = 100,
  parameter int unsigned RUN_LIMIT   = 300,
  parameter bit          TRIPLE      = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       alive,
  input  logic       run_start,
  input  logic       run_done,
  input  logic [2:0] state_code,
  output logic       hb_out
);
  logic starved;
  logic fault;
  logic kill;
  logic tick;
  logic level;

  hb_watch #(
    .ALIVE_LIMIT(ALIVE_LIMIT),
    .RUN_LIMIT  (RUN_LIMIT),
    .TRIPLE     (TRIPLE)
  ) u_watch (
    .clk      (clk),
    .rst_n    (rst_n),
    .alive    (alive),
    .run_start(run_start),
    .run_done (run_done),
    .starved  (starved),
    .fault    (fault)
  );

  assign kill = starved | fault;

  hb_tick #(
    .UNIT_CYC(UNIT_CYC)
  ) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (kill),
    .tick (tick)
  );

  hb_frame #(
    .START_U(START_U),
    .SHORT_U(SHORT_U),
    .LONG_U (LONG_U),
    .GAP_U  (GAP_U)
  ) u_frame (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(kill),
    .tick   (tick),
    .code   (state_code),
    .level  (level)
  );

  assign hb_out = level & ~kill;

  AST_FLAT_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !hb_out); // R8

  AST_FLAT_ON_STARVE: assert property (@(posedge clk) disable iff (!rst_n)
    starved |-> !hb_out); // R5

  AST_RESET_HIGH: assert property (@(posedge clk)
    !rst_n |=> hb_out); // R10

endmodule

// File: tb/hb_supervisor_test.sv
module hb_supervisor_test;
  localparam int UC = 4, SU = 4, SH = 1, LO = 2, GU = 1;
  localparam int AL = 100, RL = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alive = 1'b0;
  logic run_start = 1'b0;
  logic run_done = 1'b0;
  logic [2:0] state_code = 3'b101;
  logic hb_out;

  always #4 clk = ~clk;

  hb_supervisor #(
    .UNIT_CYC(UC), .START_U(SU), .SHORT_U(SH), .LONG_U(LO), .GAP_U(GU),
    .ALIVE_LIMIT(AL), .RUN_LIMIT(RL), .TRIPLE(1'b1)
  ) uut (
    .clk(clk), .rst_n(rst_n), .alive(alive), .run_start(run_start),
    .run_done(run_done), .state_code(state_code), .hb_out(hb_out)
  );

  int n_chk = 0;
  int n_bad = 0;
  string cur_req = "R1";
  bit alive_en = 1'b1;
  int cyc = 0;

  // Reference model state.
  bit q[$];
  bit m_valid = 1'b0;
  bit exp_hb = 1'b1;
  bit m_next_tail = 1'b1;
  int m_acnt = 0;
  int m_rcnt = 0;
  bit m_busy = 1'b0;
  bit m_fault = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, expv);
    end
  endtask

  task automatic fill_start();
    for (int i = 0; i < SU * UC; i++) q.push_back(1'b1);
  endtask

  task automatic fill_tail(input logic [2:0] c);
    for (int i = 0; i < GU * UC; i++) q.push_back(1'b0);
    for (int b = 2; b >= 0; b--) begin
      for (int i = 0; i < (c[b] ? LO : SH) * UC; i++) q.push_back(1'b1);
      for (int i = 0; i < GU * UC; i++) q.push_back(1'b0);
    end
  endtask

  always @(posedge clk) begin
    bit kill_pre, kill_post, set;
    cyc++;
    kill_pre = (m_acnt == AL) || m_fault;
    if (!rst_n) begin
      m_acnt = 0; m_rcnt = 0; m_busy = 0; m_fault = 0;
      q.delete(); fill_start(); m_next_tail = 1'b1;
      exp_hb = 1'b1;
    end else begin
      set = m_busy && (m_rcnt == RL) && !run_done && !run_start;
      if (run_start) begin m_busy = 1; m_rcnt = 0; end
      else if (run_done) begin m_busy = 0; m_rcnt = 0; end
      else if (m_busy && m_rcnt < RL) m_rcnt++;
      if (set) m_fault = 1'b1;
      if (alive) m_acnt = 0;
      else if (m_acnt < AL) m_acnt++;
      kill_post = (m_acnt == AL) || m_fault;
      if (kill_pre) begin
        q.delete(); fill_start(); m_next_tail = 1'b1;
      end else begin
        void'(q.pop_front());
        if (q.size() == 0) begin
          if (m_next_tail) begin fill_tail(state_code); m_next_tail = 1'b0; end
          else begin fill_start(); m_next_tail = 1'b1; end
        end
      end
      exp_hb = kill_post ? 1'b0 : q[0];
    end
    m_valid = 1'b1;
  end

  // Cycle-by-cycle comparison away from the active edge.
  always @(negedge clk) begin
    if (m_valid) chk(hb_out === exp_hb, cur_req, int'(hb_out), int'(exp_hb));
  end

  // Alive strobe generator: one pulse every 20 cycles when enabled.
  initial begin
    forever begin
      repeat (19) @(negedge clk);
      alive = alive_en;
      @(negedge clk);
      alive = 1'b0;
    end
  end

  task automatic pulse_start();
    @(negedge clk); run_start = 1'b1;
    @(negedge clk); run_start = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // Watchdog.
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    finish_run();
  end

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(hb_out === 1'b1, "R1", int'(hb_out), 1);
    cur_req = "R2/R4";
    repeat (600) @(negedge clk);

    // R3: code changes at arbitrary times
    cur_req = "R3";
    for (int k = 0; k < 60; k++) begin
      repeat (7) @(negedge clk);
      state_code = state_code + 3'd3;
    end

    // R5 starvation, then R6 recovery
    cur_req = "R5";
    alive_en = 1'b0;
    repeat (AL + 40) @(negedge clk);
    chk(hb_out === 1'b0, "R5", int'(hb_out), 0);
    cur_req = "R6";
    alive_en = 1'b1;
    repeat (200) @(negedge clk);

    // R7: done on the last permitted edge
    cur_req = "R7";
    pulse_start();
    repeat (RL) @(negedge clk);
    run_done = 1'b1;
    @(negedge clk); run_done = 1'b0;
    repeat (100) @(negedge clk);
    chk(m_fault == 1'b0 && hb_out !== 1'bx, "R7", int'(m_fault), 0);

    // R9: start and done together restart the run; stray done ignored
    cur_req = "R9";
    pulse_start();
    repeat (200) @(negedge clk);
    run_start = 1'b1; run_done = 1'b1;
    @(negedge clk); run_start = 1'b0; run_done = 1'b0;
    repeat (RL - 50) @(negedge clk);
    run_done = 1'b1;
    @(negedge clk); run_done = 1'b0;
    repeat (20) @(negedge clk);
    run_done = 1'b1;
    @(negedge clk); run_done = 1'b0;
    repeat (100) @(negedge clk);

    // R8: overrun latches a flat line
    cur_req = "R8";
    pulse_start();
    repeat (RL + 30) @(negedge clk);
    chk(hb_out === 1'b0, "R8", int'(hb_out), 0);
    repeat (200) @(negedge clk);
    chk(hb_out === 1'b0, "R8", int'(hb_out), 0);

    // R10: reset clears the fault
    cur_req = "R10";
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk(hb_out === 1'b1, "R10", int'(hb_out), 1);
    repeat (300) @(negedge clk);
    finish_run();
  end

endmodule